// File: doc/BRIEF.md
# CAN bus failure confirmation logic

This block is the digital diagnostic engine of a CAN transceiver. It watches the transmit data line and four synchronized threshold comparators: a ground-side pair near 1.75 V and a supply-side pair just below the 5 V supply, each pair with one comparator on CANH and one on CANL. In every transmit cycle it takes one comparator snapshot during the recessive driver phase and one during the dominant phase. Each snapshot is taken a fixed number of clocks after the TXD edge, so loop propagation delay does not corrupt it. The recessive snapshot shows that a line is shorted to ground or to battery. The dominant snapshot, taken while the driver is on, shows which line it is.

A classification is reported only after the identical result has been produced on a run of consecutive recessive-then-dominant cycles (five by default). Separately, a run-length timer flags a bus that stays dominant too long as a clamp fault. A reported fault raises a sticky bus-failure flag and loads a fault code. Software reads both and clears the flag with a write strobe.

Top module: `can_fault_confirm`

## Requirements
- R1: After reset, `bus_fail` is 0, `fault_code` is 0 and `fault_event` is 0.
- R2: Comparator bits are grouped as {sup_h, sup_l, gnd_h, gnd_l}. Priority 1: both ground comparators low in the recessive snapshot means a ground fault. It is code 3 (CANL to ground) if `gnd_h` is high in the dominant snapshot, otherwise code 4 (CANH to ground).
- R3: Priority 2: both supply comparators high in the recessive snapshot means a battery fault. It is code 5 (CANL to battery) if `sup_l` is high in the dominant snapshot, otherwise code 6 (CANH to battery).
- R4: Priority 3, otherwise: `sup_l` high in the dominant snapshot gives code 1 (CANL to 5 V). Failing that, `sup_h` high gives code 2 (CANH to 5 V). Otherwise the cycle is code 0 (no failure).
- R5: A snapshot is taken SAMPLE_DLY clocks after a TXD edge. A phase shorter than that yields no snapshot. A classification needs a recessive snapshot followed by a dominant snapshot of the same cycle.
- R6: A nonzero classification is reported only on the CONFIRM_N-th consecutive identical result. With one cycle fewer, no report is made.
- R7: A cycle whose classification differs from the previous one restarts the count at one with the new classification as candidate.
- R8: When `rx_dom` stays high for DOM_TIMEOUT consecutive clocks, a clamp fault (code 7) is reported. A shorter run reports nothing.
- R9: `bus_fail` stays set until `clr_fail` is pulsed. The clear also returns `fault_code` to 0.
- R10: `fault_event` pulses once when `bus_fail` rises. A further fault while the flag is set updates `fault_code` without a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txd | input | 1 | Synchronized transmit data, 1 = recessive |
| rx_dom | input | 1 | Receiver reports a dominant bus |
| cmp_gnd_h | input | 1 | CANH above the ground-side threshold |
| cmp_gnd_l | input | 1 | CANL above the ground-side threshold |
| cmp_sup_h | input | 1 | CANH above the supply-side threshold |
| cmp_sup_l | input | 1 | CANL above the supply-side threshold |
| clr_fail | input | 1 | Software clear strobe for the failure flag |
| fault_code | output | 3 | Last reported fault code |
| bus_fail | output | 1 | Sticky bus-failure flag |
| fault_event | output | 1 | One-clock pulse when the flag rises |

## Verification
The bench builds the block with SAMPLE_DLY = 3, CONFIRM_N = 5 and DOM_TIMEOUT = 40, and uses 8-clock driver phases. A phase of 2 clocks then falls below the snapshot delay, and the clamp boundary can be probed at 39 and 45 clocks. Keeping CONFIRM_N at 5 lets the bench compare four matching cycles with five, and show that one odd cycle in the middle of a run restarts the count.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_L_5V  = 3'd1,
    FLT_H_5V  = 3'd2,
    FLT_L_GND = 3'd3,
    FLT_H_GND = 3'd4,
    FLT_L_BAT = 3'd5,
    FLT_H_BAT = 3'd6,
    FLT_CLAMP = 3'd7
  } flt_e;

  typedef struct packed {
    logic sup_h;
    logic sup_l;
    logic gnd_h;
    logic gnd_l;
  } cmp_t;

  // Priority decode of a recessive/dominant snapshot pair (R2, R3, R4)
  function automatic flt_e classify(cmp_t r, cmp_t d);
    if (!r.gnd_h && !r.gnd_l) return d.gnd_h ? FLT_L_GND : FLT_H_GND;
    if (r.sup_h && r.sup_l)   return d.sup_l ? FLT_L_BAT : FLT_H_BAT;
    if (d.sup_l)              return FLT_L_5V;
    if (d.sup_h)              return FLT_H_5V;
    return FLT_NONE;
  endfunction

endpackage

// File: rtl/cfc_phase_sampler.sv
module cfc_phase_sampler
  import cfc_pkg::*;
#(
  parameter int SAMPLE_DLY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic txd,
  input  cmp_t cmp,
  output cmp_t rec_s,
  output cmp_t dom_s,
  output logic pair_v
);
  localparam int CW = $clog2(SAMPLE_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(SAMPLE_DLY - 1);

  logic          txd_q;
  logic [CW-1:0] cnt;
  logic          arm_rec, arm_dom, rec_have;
  logic          rise, fall;

  assign rise = txd & ~txd_q;
  assign fall = ~txd & txd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_q    <= 1'b0;
      cnt      <= '0;
      arm_rec  <= 1'b0;
      arm_dom  <= 1'b0;
      rec_have <= 1'b0;
      pair_v   <= 1'b0;
      rec_s    <= '0;
      dom_s    <= '0;
    end else begin
      txd_q  <= txd;
      pair_v <= 1'b0;
      if (rise) begin
        cnt      <= '0;
        arm_rec  <= 1'b1;
        arm_dom  <= 1'b0;
        rec_have <= 1'b0;
      end else if (fall) begin
        cnt     <= '0;
        arm_dom <= 1'b1;
        arm_rec <= 1'b0;
      end else if (arm_rec || arm_dom) begin
        if (cnt == LAST) begin
          if (arm_rec) begin
            rec_s    <= cmp;
            rec_have <= 1'b1;
            arm_rec  <= 1'b0;
          end else begin
            dom_s    <= cmp;
            arm_dom  <= 1'b0;
            rec_have <= 1'b0;
            pair_v   <= rec_have;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_one_phase_R5: assert property (@(posedge clk) disable iff (rst)
    !(arm_rec && arm_dom));
  assert_pair_after_dom_R5: assert property (@(posedge clk) disable iff (rst)
    pair_v |-> $past(arm_dom) && !txd_q);

endmodule

// File: rtl/cfc_classify.sv
module cfc_classify
  import cfc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pair_v,
  input  cmp_t rec_s,
  input  cmp_t dom_s,
  output logic cls_v,
  output flt_e cls_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cls_v    <= 1'b0;
      cls_code <= FLT_NONE;
    end else begin
      cls_v <= pair_v;
      if (pair_v) cls_code <= classify(rec_s, dom_s);
    end
  end

  assert_no_clamp_code_R2: assert property (@(posedge clk) disable iff (rst)
    cls_v |-> cls_code != FLT_CLAMP);

endmodule

// File: rtl/cfc_confirm.sv
module cfc_confirm
  import cfc_pkg::*;
#(
  parameter int CONFIRM_N = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic cls_v,
  input  flt_e cls_code,
  output logic conf_p,
  output flt_e conf_code
);
  localparam int CW = $clog2(CONFIRM_N + 1);
  localparam logic [CW-1:0] TOP  = CW'(CONFIRM_N);
  localparam logic [CW-1:0] PREV = CW'(CONFIRM_N - 1);

  flt_e          cand;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cand      <= FLT_NONE;
      cnt       <= '0;
      conf_p    <= 1'b0;
      conf_code <= FLT_NONE;
    end else begin
      conf_p <= 1'b0;
      if (cls_v) begin
        if (cls_code == cand && cnt != '0) begin
          if (cnt != TOP) cnt <= cnt + 1'b1;
          if (cnt == PREV && cand != FLT_NONE) begin
            conf_p    <= 1'b1;
            conf_code <= cand;
          end
        end else begin
          cand <= cls_code;
          cnt  <= CW'(1);
        end
      end
    end
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);
  assert_confirm_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    conf_p |-> conf_code != FLT_NONE && cnt == TOP);
  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    cls_v && cls_code != cand |=> cnt == CW'(1));

endmodule

// File: rtl/cfc_dom_timer.sv
module cfc_dom_timer #(
  parameter int DOM_TIMEOUT = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_dom,
  output logic clamp_p
);
  localparam int CW = $clog2(DOM_TIMEOUT + 1);
  localparam logic [CW-1:0] LIM  = CW'(DOM_TIMEOUT);
  localparam logic [CW-1:0] LIM1 = CW'(DOM_TIMEOUT - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= '0;
      clamp_p <= 1'b0;
    end else begin
      clamp_p <= rx_dom && run == LIM1;
      if (!rx_dom)         run <= '0;
      else if (run != LIM) run <= run + 1'b1;
    end
  end

  assert_clamp_needs_dom_R8: assert property (@(posedge clk) disable iff (rst)
    clamp_p |-> $past(rx_dom));
  assert_run_clears_R8: assert property (@(posedge clk) disable iff (rst)
    !rx_dom |=> run == '0 && !clamp_p);

endmodule

// File: rtl/can_fault_confirm.sv
module can_fault_confirm
  import cfc_pkg::*;
#(
  parameter int SAMPLE_DLY  = 3,
  parameter int CONFIRM_N   = 5,
  parameter int DOM_TIMEOUT = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txd,
  input  logic       rx_dom,
  input  logic       cmp_gnd_h,
  input  logic       cmp_gnd_l,
  input  logic       cmp_sup_h,
  input  logic       cmp_sup_l,
  input  logic       clr_fail,
  output logic [2:0] fault_code,
  output logic       bus_fail,
  output logic       fault_event
);
  cmp_t cmp_now, rec_s, dom_s;
  logic pair_v, cls_v, conf_p, clamp_p, new_v;
  flt_e cls_code, conf_code, new_code;
  flt_e code_q;

  assign cmp_now = '{sup_h: cmp_sup_h, sup_l: cmp_sup_l, gnd_h: cmp_gnd_h, gnd_l: cmp_gnd_l};

  cfc_phase_sampler #(.SAMPLE_DLY(SAMPLE_DLY)) u_sampler (
    .clk(clk), .rst(rst), .txd(txd), .cmp(cmp_now),
    .rec_s(rec_s), .dom_s(dom_s), .pair_v(pair_v)
  );

  cfc_classify u_classify (
    .clk(clk), .rst(rst), .pair_v(pair_v), .rec_s(rec_s), .dom_s(dom_s),
    .cls_v(cls_v), .cls_code(cls_code)
  );

  cfc_confirm #(.CONFIRM_N(CONFIRM_N)) u_confirm (
    .clk(clk), .rst(rst), .cls_v(cls_v), .cls_code(cls_code),
    .conf_p(conf_p), .conf_code(conf_code)
  );

  cfc_dom_timer #(.DOM_TIMEOUT(DOM_TIMEOUT)) u_dom_timer (
    .clk(clk), .rst(rst), .rx_dom(rx_dom), .clamp_p(clamp_p)
  );

  // Clamp takes precedence when both sources report in the same clock
  assign new_v    = conf_p | clamp_p;
  assign new_code = clamp_p ? FLT_CLAMP : conf_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_fail    <= 1'b0;
      code_q      <= FLT_NONE;
      fault_event <= 1'b0;
    end else begin
      fault_event <= 1'b0;
      if (new_v) begin
        code_q      <= new_code;
        bus_fail    <= 1'b1;
        fault_event <= !bus_fail || clr_fail;
      end else if (clr_fail) begin
        bus_fail <= 1'b0;
        code_q   <= FLT_NONE;
      end
    end
  end

  assign fault_code = code_q;

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    bus_fail && !clr_fail |=> bus_fail);
  assert_no_second_event_R10: assert property (@(posedge clk) disable iff (rst)
    bus_fail && !clr_fail |=> !fault_event);
  assert_event_sets_flag_R10: assert property (@(posedge clk) disable iff (rst)
    fault_event |-> bus_fail);
  assert_flag_has_code_R9: assert property (@(posedge clk) disable iff (rst)
    bus_fail |-> fault_code != 3'd0);

endmodule

// File: tb/can_fault_confirm_bench.sv
module can_fault_confirm_bench;
  localparam int PH = 8;

  logic clk = 1'b0;
  logic rst, txd, rx_dom, clr_fail;
  logic [3:0] cmp;
  logic [2:0] fault_code;
  logic bus_fail, fault_event;
  int total = 0, bad = 0, ev_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  can_fault_confirm #(.SAMPLE_DLY(3), .CONFIRM_N(5), .DOM_TIMEOUT(40)) u_can_fault_confirm (
    .clk(clk), .rst(rst), .txd(txd), .rx_dom(rx_dom),
    .cmp_gnd_h(cmp[1]), .cmp_gnd_l(cmp[0]), .cmp_sup_h(cmp[3]), .cmp_sup_l(cmp[2]),
    .clr_fail(clr_fail), .fault_code(fault_code), .bus_fail(bus_fail),
    .fault_event(fault_event)
  );

  always @(posedge clk) if (!rst && fault_event) ev_cnt <= ev_cnt + 1;

  // {recessive cmp, dominant cmp, cycles, expected code, expected flag}, cmp = {sup_h,sup_l,gnd_h,gnd_l}
  localparam logic [15:0] VEC [8] = '{
    {4'b0011, 4'b0010, 4'd6, 3'd0, 1'b0},  // R4 clean bus
    {4'b0000, 4'b0010, 4'd5, 3'd3, 1'b1},  // R2 CANL to ground
    {4'b0000, 4'b0000, 4'd5, 3'd4, 1'b1},  // R2 CANH to ground
    {4'b1111, 4'b0111, 4'd5, 3'd5, 1'b1},  // R3 CANL to battery
    {4'b1111, 4'b1010, 4'd5, 3'd6, 1'b1},  // R3 CANH to battery
    {4'b0011, 4'b0110, 4'd5, 3'd1, 1'b1},  // R4 CANL to 5 V
    {4'b0011, 4'b1010, 4'd5, 3'd2, 1'b1},  // R4 CANH to 5 V
    {4'b0000, 4'b0010, 4'd4, 3'd0, 1'b0}   // R6 one cycle short
  };

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; txd = 0; rx_dom = 0; clr_fail = 0; cmp = 4'b0010;
    repeat (3) @(negedge clk);
    rst = 0;
    ev_cnt = 0;
    @(negedge clk);
  endtask

  task automatic run_cycles(input logic [3:0] rc, input logic [3:0] dc, input int n,
                            input int rec_len);
    for (int i = 0; i < n; i++) begin
      txd = 1; cmp = rc;
      repeat (rec_len) @(negedge clk);
      txd = 0; cmp = dc;
      repeat (PH) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_clear();
    clr_fail = 1; @(negedge clk); clr_fail = 0; @(negedge clk);
  endtask

  initial begin
    rst = 1; txd = 0; rx_dom = 0; clr_fail = 0; cmp = 4'b0010;
    do_reset();
    check(bus_fail, 0, "R1 flag after reset");
    check(fault_code, 0, "R1 code after reset");
    check(fault_event, 0, "R1 event after reset");

    for (int v = 0; v < 8; v++) begin
      do_reset();
      run_cycles(VEC[v][15:12], VEC[v][11:8], int'(VEC[v][7:4]), PH);
      check(fault_code, int'(VEC[v][3:1]), $sformatf("R2/R3/R4/R6 vector %0d code", v));
      check(bus_fail, int'(VEC[v][0]), $sformatf("R6 vector %0d flag", v));
    end

    // R7: a differing cycle in the middle restarts the count
    do_reset();
    run_cycles(4'b0000, 4'b0010, 4, PH);
    run_cycles(4'b0000, 4'b0000, 1, PH);
    run_cycles(4'b0000, 4'b0010, 4, PH);
    check(bus_fail, 0, "R7 interrupted run not reported");
    run_cycles(4'b0000, 4'b0010, 1, PH);
    check(fault_code, 3, "R7 fifth after restart reports");

    // R5: recessive phase shorter than the snapshot delay gives no pair
    do_reset();
    run_cycles(4'b0000, 4'b0010, 6, 2);
    check(bus_fail, 0, "R5 short recessive phase ignored");
    check(fault_code, 0, "R5 short phase code");

    // R9 / R10: sticky flag, single event, code update
    do_reset();
    run_cycles(4'b0000, 4'b0010, 5, PH);
    run_cycles(4'b0011, 4'b0010, 6, PH);
    check(bus_fail, 1, "R9 flag survives clean cycles");
    check(fault_code, 3, "R9 code kept");
    run_cycles(4'b1111, 4'b1010, 5, PH);
    check(fault_code, 6, "R10 code updated");
    check(ev_cnt, 1, "R10 single event");
    pulse_clear();
    check(bus_fail, 0, "R9 clear drops flag");
    check(fault_code, 0, "R9 clear zeroes code");

    // R8: dominant clamp timeout
    do_reset();
    rx_dom = 1; repeat (39) @(negedge clk); rx_dom = 0;
    repeat (4) @(negedge clk);
    check(bus_fail, 0, "R8 run of 39 below timeout");
    rx_dom = 1; repeat (45) @(negedge clk); rx_dom = 0;
    repeat (4) @(negedge clk);
    check(bus_fail, 1, "R8 clamp flag");
    check(fault_code, 7, "R8 clamp code");
    check(ev_cnt, 1, "R10 clamp event");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule